// File: doc/BRIEF.md
# Load-Reserve / Store-Conditional Reservation Monitor

This block sits between a core's load/store pipeline and a word-wide memory port and implements the reservation half of an atomic read-modify-write sequence. A load-and-reserve request reads one word and remembers its address in a single reservation register. A later store-conditional request writes its word only when its address still matches that live reservation. It reports the outcome as a 4-bit condition field. Every store-conditional consumes the reservation, whether it succeeds, fails or faults.

Both request types require word alignment. A request whose low address bits are nonzero performs no memory access and returns an alignment exception strobe. A per-request endian select byte-reverses the word on both the load return path and the store data path. A valid flag kept beside the reserved address stops a cleared reservation (address zero) from matching a store-conditional to address zero.

Requests are single-cycle. The memory port strobes are combinational in the request cycle. The memory returns read data one cycle later. All responses (load data, condition field, exception) appear in the cycle after the request.

Top module: `lrsc_monitor`

## Requirements
- R1: A request whose address has either of its two low bits set asserts `align_exc` for one cycle in the next cycle. It asserts neither `mem_rd` nor `mem_wr`, and produces neither `ld_valid` nor `cr_valid`.
- R2: An aligned load-and-reserve (`req_op`=0) asserts `mem_rd` with `mem_addr`=`req_addr`. In the next cycle it raises `ld_valid` with `ld_data` holding the word read. It records the address as the live reservation.
- R3: An aligned store-conditional (`req_op`=1) whose address equals the live reserved address asserts `mem_wr` with the store data. Its condition field is bit1 (equal) = 1 and bit0 = `so_in`, with bits 3:2 zero.
- R4: A store-conditional whose address does not match a live reservation performs no write. Its condition field is `so_in` in bit0 with bits 3:1 zero.
- R5: Every store-conditional, including one that takes the alignment exception, leaves no live reservation afterwards.
- R6: With `req_le`=1, both the returned load word and the written store word are byte-reversed: byte 0 (bits 7:0) swaps with byte 3 (bits 31:24), and byte 1 swaps with byte 2. With `req_le`=0 the data passes unchanged.
- R7: After the reservation is cleared, a store-conditional to address zero fails; a cleared reservation is never treated as live at address zero.
- R8: `cr_valid` is a one-cycle strobe in the cycle after an aligned store-conditional, and is low otherwise.
- R9: Reset leaves no live reservation and drives all response outputs low.
- R10: A misaligned load-and-reserve leaves the existing reservation unchanged. A new aligned load-and-reserve replaces any older reservation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 1 | 0 = load-and-reserve, 1 = store-conditional |
| req_addr | input | 16 | Byte address of the request |
| req_wdata | input | 32 | Store data for store-conditional |
| req_le | input | 1 | 1 = little-endian byte order for this request |
| so_in | input | 1 | Summary-overflow bit copied into the condition field |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_addr | output | 16 | Memory word address (request address) |
| mem_wdata | output | 32 | Memory write data after endian handling |
| mem_rdata | input | 32 | Memory read data, valid one cycle after `mem_rd` |
| ld_valid | output | 1 | Load result valid |
| ld_data | output | 32 | Load result after endian handling |
| cr_valid | output | 1 | Condition field valid strobe |
| cr_field | output | 4 | Store-conditional condition field |
| align_exc | output | 1 | Alignment exception strobe |

## Verification
The bench goes after reservation lifetime. A store-conditional that faults on alignment must still kill the reservation; a design that skipped the clear would let the following matching store write. After a clear, a store to address zero must fail; a design without the valid flag would report success and corrupt memory. A misaligned load must not disturb the reservation, and a second load must replace the first; mistakes there show up as a wrong equal bit. Byte-reversal is checked on both paths by reading back a little-endian store with a big-endian load, which catches swaps applied on one path only or with the wrong byte pairing.

// File: rtl/lrsc_pkg.sv
// Shared definitions for the reservation monitor.
package lrsc_pkg;
    // Request kind carried on req_op.
    typedef enum logic {
        OP_LOAD_RSV   = 1'b0,
        OP_STORE_COND = 1'b1
    } lrsc_op_e;

    // Condition field layout; the core decodes these bit positions.
    localparam int CR_W      = 4;
    localparam int CR_SO_BIT = 0;
    localparam int CR_EQ_BIT = 1;
endpackage

// File: rtl/lrsc_byteswap.sv
// Byte-order converter.
// Reverses the byte order of a word when en is high, passes it through otherwise.
// Assumes the word is a whole number of 8-bit bytes.
module lrsc_byteswap #(
    parameter int BYTES = 4
) (
    input  logic                 en,
    input  logic [8*BYTES-1:0]   din,
    output logic [8*BYTES-1:0]   dout
);
    localparam int DW = 8 * BYTES;

    logic [DW-1:0] reversed;

    // Mirror byte lanes: lane i takes lane BYTES-1-i.
    for (genvar i = 0; i < BYTES; i++) begin : g_lane
        assign reversed[8*i +: 8] = din[8*(BYTES-1-i) +: 8];
    end

    // Select reversed or straight data.
    always_comb dout = en ? reversed : din;
endmodule

// File: rtl/lrsc_resv.sv
// Reservation register.
// Holds one reserved address plus a valid flag. A clear request wins by design
// intent, but set and clear never arrive together (they come from different
// request kinds). Assumes synchronous active-low reset.
module lrsc_resv #(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          set_i,
    input  logic          clr_i,
    input  logic [AW-1:0] addr_i,
    output logic          valid_o,
    output logic [AW-1:0] addr_o
);
    // Update the reservation on set, drop it on clear or reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_o <= 1'b0;
            addr_o  <= '0;
        end else if (clr_i) begin
            valid_o <= 1'b0;
            addr_o  <= '0;
        end else if (set_i) begin
            valid_o <= 1'b1;
            addr_o  <= addr_i;
        end
    end

    // R5: a store-conditional always leaves no live reservation.
    a_r5_sc_clears: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> !valid_o);

    // R9: reset leaves no live reservation.
    a_r9_reset_clears: assert property (@(posedge clk)
        !rst_n |=> !valid_o);

    // R10: a set with no clear makes the new address live.
    a_r10_set_replaces: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i && !clr_i) |=> (valid_o && addr_o == $past(addr_i)));
endmodule

// File: rtl/lrsc_ctrl.sv
// Request decoder and response register stage.
// Checks alignment, decides memory strobes and reservation updates in the
// request cycle, and registers the responses for the following cycle.
// Assumes one request per cycle at most and memory read latency of one cycle.
module lrsc_ctrl
    import lrsc_pkg::*;
#(
    parameter int AW         = 16,
    parameter int WORD_BYTES = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic            req_op,
    input  logic [AW-1:0]   req_addr,
    input  logic            req_le,
    input  logic            so_in,
    input  logic            resv_valid,
    input  logic [AW-1:0]   resv_addr,
    output logic            mem_rd_o,
    output logic            mem_wr_o,
    output logic            rsv_set_o,
    output logic            rsv_clr_o,
    output logic            ld_valid_o,
    output logic            ld_le_o,
    output logic            cr_valid_o,
    output logic [CR_W-1:0] cr_field_o,
    output logic            align_exc_o
);
    localparam int OFS_W = $clog2(WORD_BYTES);

    logic            is_lr;
    logic            is_sc;
    logic            misaligned;
    logic            addr_hit;
    logic [CR_W-1:0] cr_next;

    // Decode the request and compare it against the reservation.
    always_comb begin
        is_lr      = req_valid && (req_op == OP_LOAD_RSV);
        is_sc      = req_valid && (req_op == OP_STORE_COND);
        misaligned = |req_addr[OFS_W-1:0];
        addr_hit   = resv_valid && (resv_addr == req_addr);
    end

    // Memory strobes and reservation control for this cycle.
    always_comb begin
        mem_rd_o  = is_lr && !misaligned;
        mem_wr_o  = is_sc && !misaligned && addr_hit;
        rsv_set_o = is_lr && !misaligned;
        rsv_clr_o = is_sc;
    end

    // Build the condition field: overflow bit plus equal bit on success.
    always_comb begin
        cr_next            = '0;
        cr_next[CR_SO_BIT] = so_in;
        cr_next[CR_EQ_BIT] = is_sc && !misaligned && addr_hit;
    end

    // Register responses for the cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ld_valid_o  <= 1'b0;
            ld_le_o     <= 1'b0;
            cr_valid_o  <= 1'b0;
            cr_field_o  <= '0;
            align_exc_o <= 1'b0;
        end else begin
            ld_valid_o  <= is_lr && !misaligned;
            ld_le_o     <= req_le;
            cr_valid_o  <= is_sc && !misaligned;
            cr_field_o  <= (is_sc && !misaligned) ? cr_next : '0;
            align_exc_o <= (is_lr || is_sc) && misaligned;
        end
    end

    // R1: a misaligned request touches no memory.
    a_r1_no_access: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && misaligned) |-> (!mem_rd_o && !mem_wr_o));

    // R1: an alignment exception carries no other response.
    a_r1_exc_alone: assert property (@(posedge clk) disable iff (!rst_n)
        align_exc_o |-> (!cr_valid_o && !ld_valid_o));

    // R8: the condition strobe follows an aligned store-conditional.
    a_r8_strobe_source: assert property (@(posedge clk) disable iff (!rst_n)
        cr_valid_o |-> $past(is_sc && !misaligned));

    // R4: a failed store-conditional reports no equal bit.
    a_r4_fail_no_eq: assert property (@(posedge clk) disable iff (!rst_n)
        (is_sc && !mem_wr_o) |=> !cr_field_o[CR_EQ_BIT]);
endmodule

// File: rtl/lrsc_monitor.sv
// Load-reserve / store-conditional reservation monitor (top).
// Ties the decoder, the reservation register and the two byte-order
// converters to a word memory port. Memory read data must arrive one cycle
// after mem_rd. Synchronous active-low reset.
module lrsc_monitor
    import lrsc_pkg::*;
#(
    parameter int AW         = 16,
    parameter int WORD_BYTES = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    input  logic                    req_op,
    input  logic [AW-1:0]           req_addr,
    input  logic [8*WORD_BYTES-1:0] req_wdata,
    input  logic                    req_le,
    input  logic                    so_in,
    output logic                    mem_rd,
    output logic                    mem_wr,
    output logic [AW-1:0]           mem_addr,
    output logic [8*WORD_BYTES-1:0] mem_wdata,
    input  logic [8*WORD_BYTES-1:0] mem_rdata,
    output logic                    ld_valid,
    output logic [8*WORD_BYTES-1:0] ld_data,
    output logic                    cr_valid,
    output logic [CR_W-1:0]         cr_field,
    output logic                    align_exc
);
    localparam int DW = 8 * WORD_BYTES;

    logic          resv_valid;
    logic [AW-1:0] resv_addr;
    logic          rsv_set;
    logic          rsv_clr;
    logic          ld_le;
    logic [DW-1:0] ld_ordered;

    lrsc_ctrl #(.AW(AW), .WORD_BYTES(WORD_BYTES)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_op      (req_op),
        .req_addr    (req_addr),
        .req_le      (req_le),
        .so_in       (so_in),
        .resv_valid  (resv_valid),
        .resv_addr   (resv_addr),
        .mem_rd_o    (mem_rd),
        .mem_wr_o    (mem_wr),
        .rsv_set_o   (rsv_set),
        .rsv_clr_o   (rsv_clr),
        .ld_valid_o  (ld_valid),
        .ld_le_o     (ld_le),
        .cr_valid_o  (cr_valid),
        .cr_field_o  (cr_field),
        .align_exc_o (align_exc)
    );

    lrsc_resv #(.AW(AW)) u_resv (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (rsv_set),
        .clr_i   (rsv_clr),
        .addr_i  (req_addr),
        .valid_o (resv_valid),
        .addr_o  (resv_addr)
    );

    lrsc_byteswap #(.BYTES(WORD_BYTES)) u_st_swap (
        .en   (req_le),
        .din  (req_wdata),
        .dout (mem_wdata)
    );

    lrsc_byteswap #(.BYTES(WORD_BYTES)) u_ld_swap (
        .en   (ld_le),
        .din  (mem_rdata),
        .dout (ld_ordered)
    );

    // Address goes straight to the memory port.
    always_comb mem_addr = req_addr;

    // Load data is driven only while the load response is valid.
    always_comb ld_data = ld_valid ? ld_ordered : '0;

    // R3: a write only ever targets the live reserved address.
    a_r3_write_hits_resv: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> (resv_valid && resv_addr == mem_addr));

    // R2: a read strobe yields a load response next cycle.
    a_r2_read_returns: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> ld_valid);
endmodule

// File: tb/lrsc_monitor_tb.sv
module lrsc_monitor_tb;
    typedef struct packed {
        logic        op;
        logic [15:0] addr;
        logic [31:0] wdata;
        logic        le;
        logic        so;
        logic        exc;
        logic        crv;
        logic [3:0]  cr;
        logic        ldv;
        logic [31:0] ldd;
    } vec_t;

    localparam int NV = 23;
    // Memory word i starts as 32'h11223300 + i; index = addr[5:2].
    localparam vec_t VECS [NV] = '{
        '{1'b0, 16'h0004, 32'h0,        1'b0, 1'b0, 1'b0, 1'b0, 4'h0, 1'b1, 32'h11223301}, // R2
        '{1'b1, 16'h0004, 32'hCAFEF00D, 1'b0, 1'b0, 1'b0, 1'b1, 4'h2, 1'b0, 32'h0},        // R3
        '{1'b0, 16'h0004, 32'h0,        1'b0, 1'b0, 1'b0, 1'b0, 4'h0, 1'b1, 32'hCAFEF00D}, // R3 write seen
        '{1'b1, 16'h0008, 32'hDEADBEEF, 1'b0, 1'b1, 1'b0, 1'b1, 4'h1, 1'b0, 32'h0},        // R4 mismatch
        '{1'b0, 16'h0008, 32'h0,        1'b0, 1'b0, 1'b0, 1'b0, 4'h0, 1'b1, 32'h11223302}, // R4 no write
        '{1'b1, 16'h0008, 32'h01020304, 1'b1, 1'b1, 1'b0, 1'b1, 4'h3, 1'b0, 32'h0},        // R3 R6 store
        '{1'b0, 16'h0008, 32'h0,        1'b0, 1'b0, 1'b0, 1'b0, 4'h0, 1'b1, 32'h04030201}, // R6
        '{1'b0, 16'h000C, 32'h0,        1'b1, 1'b0, 1'b0, 1'b0, 4'h0, 1'b1, 32'h03332211}, // R6 load
        '{1'b1, 16'h000E, 32'h0,        1'b0, 1'b0, 1'b1, 1'b0, 4'h0, 1'b0, 32'h0},        // R1 R5
        '{1'b1, 16'h000C, 32'h12345678, 1'b0, 1'b0, 1'b0, 1'b1, 4'h0, 1'b0, 32'h0},        // R5 killed
        '{1'b0, 16'h0001, 32'h0,        1'b0, 1'b0, 1'b1, 1'b0, 4'h0, 1'b0, 32'h0},        // R1
        '{1'b0, 16'h0000, 32'h0,        1'b0, 1'b0, 1'b0, 1'b0, 4'h0, 1'b1, 32'h11223300}, // R2
        '{1'b1, 16'h0000, 32'h00000055, 1'b0, 1'b0, 1'b0, 1'b1, 4'h2, 1'b0, 32'h0},        // R3 at zero
        '{1'b1, 16'h0000, 32'h000000AA, 1'b0, 1'b0, 1'b0, 1'b1, 4'h0, 1'b0, 32'h0},        // R7
        '{1'b0, 16'h0000, 32'h0,        1'b0, 1'b0, 1'b0, 1'b0, 4'h0, 1'b1, 32'h00000055}, // R7 no write
        '{1'b0, 16'h0010, 32'h0,        1'b0, 1'b0, 1'b0, 1'b0, 4'h0, 1'b1, 32'h11223304}, // R2
        '{1'b0, 16'h0013, 32'h0,        1'b0, 1'b0, 1'b1, 1'b0, 4'h0, 1'b0, 32'h0},        // R10 misaligned
        '{1'b1, 16'h0010, 32'h00000077, 1'b0, 1'b0, 1'b0, 1'b1, 4'h2, 1'b0, 32'h0},        // R10 kept
        '{1'b0, 16'h0010, 32'h0,        1'b0, 1'b0, 1'b0, 1'b0, 4'h0, 1'b1, 32'h00000077}, // R3
        '{1'b0, 16'h0014, 32'h0,        1'b0, 1'b0, 1'b0, 1'b0, 4'h0, 1'b1, 32'h11223305}, // R2
        '{1'b0, 16'h0018, 32'h0,        1'b0, 1'b0, 1'b0, 1'b0, 4'h0, 1'b1, 32'h11223306}, // R10 replace
        '{1'b1, 16'h0014, 32'h00000099, 1'b0, 1'b1, 1'b0, 1'b1, 4'h1, 1'b0, 32'h0},        // R10 R4
        '{1'b0, 16'h0014, 32'h0,        1'b0, 1'b0, 1'b0, 1'b0, 4'h0, 1'b1, 32'h11223305}  // R10 no write
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_op = 1'b0;
    logic [15:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        req_le = 1'b0;
    logic        so_in = 1'b0;
    logic        mem_rd, mem_wr;
    logic [15:0] mem_addr;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        ld_valid;
    logic [31:0] ld_data;
    logic        cr_valid;
    logic [3:0]  cr_field;
    logic        align_exc;

    logic [31:0] mem [16];
    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    lrsc_monitor u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_le(req_le), .so_in(so_in),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .ld_valid(ld_valid), .ld_data(ld_data),
        .cr_valid(cr_valid), .cr_field(cr_field), .align_exc(align_exc)
    );

    // Word memory model with one-cycle read latency.
    always @(posedge clk) begin
        if (mem_rd) mem_rdata <= mem[mem_addr[5:2]];
        if (mem_wr) mem[mem_addr[5:2]] <= mem_wdata;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(input logic op, input logic [15:0] a, input logic [31:0] d,
                         input logic le, input logic so);
        req_valid = 1'b1; req_op = op; req_addr = a; req_wdata = d; req_le = le; so_in = so;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) mem[i] = 32'h11223300 + i;
        repeat (3) @(negedge clk);
        // R9: outputs low under reset.
        chk("R9 ld_valid", {31'b0, ld_valid}, 32'h0);
        chk("R9 cr_valid", {31'b0, cr_valid}, 32'h0);
        chk("R9 align_exc", {31'b0, align_exc}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 R7: store-conditional to zero right after reset fails.
        drive(1'b1, 16'h0000, 32'hFFFFFFFF, 1'b0, 1'b0);
        #1 chk("R9 mem_wr", {31'b0, mem_wr}, 32'h0);
        @(negedge clk);
        req_valid = 1'b0;
        chk("R9 cr_valid", {31'b0, cr_valid}, 32'h1);
        chk("R9 cr_field", {28'b0, cr_field}, 32'h0);
        @(negedge clk);
        // R8: strobe lasts one cycle only.
        chk("R8 cr_valid idle", {31'b0, cr_valid}, 32'h0);

        for (int v = 0; v < NV; v++) begin
            drive(VECS[v].op, VECS[v].addr, VECS[v].wdata, VECS[v].le, VECS[v].so);
            #1;
            chk("R1/R2 mem_rd", {31'b0, mem_rd}, {31'b0, VECS[v].ldv});
            chk("R1/R3/R4 mem_wr", {31'b0, mem_wr}, {31'b0, VECS[v].crv & VECS[v].cr[1]});
            if (mem_wr) chk("R6 mem_wdata", mem_wdata,
                            VECS[v].le ? {VECS[v].wdata[7:0], VECS[v].wdata[15:8],
                                          VECS[v].wdata[23:16], VECS[v].wdata[31:24]}
                                       : VECS[v].wdata);
            @(negedge clk);
            chk("R1 align_exc", {31'b0, align_exc}, {31'b0, VECS[v].exc});
            chk("R8 cr_valid", {31'b0, cr_valid}, {31'b0, VECS[v].crv});
            if (VECS[v].crv) chk("R3/R4 cr_field", {28'b0, cr_field}, {28'b0, VECS[v].cr});
            chk("R2 ld_valid", {31'b0, ld_valid}, {31'b0, VECS[v].ldv});
            if (VECS[v].ldv) chk("R2/R6 ld_data", ld_data, VECS[v].ldd);
        end
        req_valid = 1'b0;
        @(negedge clk);
        chk("R8 idle cr_valid", {31'b0, cr_valid}, 32'h0);

        // R9: reset mid-run kills a live reservation.
        drive(1'b0, 16'h0020, 32'h0, 1'b0, 1'b0);
        @(negedge clk);
        req_valid = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        drive(1'b1, 16'h0020, 32'h0, 1'b0, 1'b0);
        #1 chk("R9 no write after reset", {31'b0, mem_wr}, 32'h0);
        @(negedge clk);
        req_valid = 1'b0;
        chk("R9 cr after reset", {28'b0, cr_field}, 32'h0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule